// File: doc/BRIEF.md
# Debug Port Scan Register File

This block is the target-side register set that sits behind a JTAG TAP controller on a processor debug port. The TAP controller supplies its state strobes (capture-DR, shift-DR, update-DR, update-IR) and the instruction value. The block decodes that 5-bit instruction and routes the data-register scan path to one of these registers: a device identifier, an implementation word, the access address, the access data, a 32-bit debug control word, a 96-bit chain of all three, a 33-bit fast-data word, or a 1-bit bypass.

On the core side, a simple request port carries address, store data, direction and size. A request stays pending until the debug probe finishes it. On a store, the probe reads the address and data out of the scan. On a load, the probe first scans the data in. In both cases the probe then scans a 0 into the pending bit of the control word, or 0 into the flag bit of the fast-data word. The core then sees a one-cycle acknowledge along with the data register contents. The control word also carries a break request, probe configuration bits, a peripheral reset output and a sticky reset-occurred flag.

Top module: `debugTapRegs`

## Requirements
- R1: After reset the instruction is 0x01. On update-IR the instruction is taken from `irCode`. Code 0x01 selects the 32-bit identifier (parameter ID_VALUE), 0x03 the 32-bit implementation word (parameter IMPL_VALUE), 0x08 the address, 0x09 the data and 0x0A the control word. All of these are 32 bits.
- R2: Every other code, including 0x00, 0x02, 0x1C and 0x1F, selects a 1-bit bypass that captures 0. A bit on `tdi` therefore reaches `tdo` one shift later.
- R3: Capture-DR loads the selected register into the scan path, and `tdo` shows its bit 0 after that edge. Each shift-DR edge moves the path one place toward bit 0 and inserts `tdi` at the top bit of the selected length. Writable state changes only on update-DR.
- R4: While no access is pending and no acknowledge is being given, `coreReq` is latched as a pending access. The latch takes the address, the direction (`coreWrite`=1 is a store) and the size. On a store, `coreWdata` is also loaded into the data register.
- R5: The control word reads as follows: bit 31 reset-occurred, bits 30:29 access size (0 byte, 1 halfword, 2 word, 3 triple), bit 20 peripheral reset, bit 19 direction (1 store), bit 18 pending access, bit 15 probe enable, bit 14 probe trap, bit 12 break request, bit 3 the `debugMode` input. All other bits read 0.
- R6: An update of the control word with bit 18 = 0 completes the access, but only if bit 18 was captured as 1. Completion gives `coreAck` high for exactly the cycle after the update edge, with `coreRdata` equal to the data register. Writing 1 to bit 18 leaves the access pending.
- R7: The reset-occurred bit reads 1 after reset. Writing 0 to it clears it, and writing 1 has no effect.
- R8: Writing 1 to bit 12 raises `dbgIntReq`, and bit 12 reads 1 while the request stands. Writing 0 has no effect. The request clears on the first clock edge at which `debugMode` is 1.
- R9: Bits 20, 15 and 14 are written on every control update and drive `periphReset`, `probeEn` and `probeTrap`.
- R10: Code 0x0B selects a 96-bit chain. Bits 31:0 are the address, bits 63:32 the data and bits 95:64 the control word, with bit 0 leaving first. Data and control are committed from the chain, and R6 applies to chain bit 82.
- R11: Code 0x0E selects a 33-bit path. Bit 0 is a flag and bits 32:1 are the data. The flag is captured as 1 when an access is pending and 0 otherwise. On update the data is written. A flag of 0 completes an access captured as pending, and a flag of 1 has no effect.
- R12: The address register cannot be written through the scan path. A scan of 0x08 or of the chain leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| captureDr | input | 1 | TAP capture-DR strobe |
| shiftDr | input | 1 | TAP shift-DR strobe |
| updateDr | input | 1 | TAP update-DR strobe |
| updateIr | input | 1 | TAP update-IR strobe |
| irCode | input | 5 | Instruction value taken on update-IR |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output |
| coreReq | input | 1 | Core access request, held until acknowledged |
| coreWrite | input | 1 | 1 store, 0 load or fetch |
| coreSize | input | 2 | Access size code |
| coreAddr | input | 32 | Access address |
| coreWdata | input | 32 | Store data |
| coreAck | output | 1 | One-cycle completion pulse |
| coreRdata | output | 32 | Data register, valid with coreAck |
| debugMode | input | 1 | Core is in debug mode |
| dbgIntReq | output | 1 | Debug interrupt request |
| periphReset | output | 1 | Peripheral reset output |
| probeEn | output | 1 | Probe enable configuration |
| probeTrap | output | 1 | Probe trap configuration |

## Verification
The access handshake is run in four variants: a store completed through the control word, a load whose data is scanned in first, a load completed through the 96-bit chain, and a store completed through the fast-data path. Together these show that every completion route drives the acknowledge and returns the right data. Each route is also scanned once with the completion bit at 1, and the fast path is scanned once with nothing pending. Those scans separate a real completion from a stray pulse. The bypass codes are scanned with more bits than their width, so the serial output shows the one-bit delay. The control word is written with the sticky and set-only bits at both values, which separates clear-on-zero, set-on-one and plain read/write behaviour.

// File: rtl/debugTapPkg.sv
package debugTapPkg;
  localparam int DW    = 32;
  localparam int IR_W  = 5;
  localparam int SR_W  = 3 * DW;
  localparam int LEN_W = $clog2(SR_W);

  localparam logic [IR_W-1:0] IR_DEVID = 5'h01;
  localparam logic [IR_W-1:0] IR_IMPL  = 5'h03;
  localparam logic [IR_W-1:0] IR_ADDR  = 5'h08;
  localparam logic [IR_W-1:0] IR_DATA  = 5'h09;
  localparam logic [IR_W-1:0] IR_CTRL  = 5'h0A;
  localparam logic [IR_W-1:0] IR_CHAIN = 5'h0B;
  localparam logic [IR_W-1:0] IR_FAST  = 5'h0E;

  // control word bit positions
  localparam int B_ROCC    = 31;
  localparam int B_SIZE    = 29;
  localparam int B_PERIPH  = 20;
  localparam int B_DIR     = 19;
  localparam int B_PEND    = 18;
  localparam int B_PENABLE = 15;
  localparam int B_PTRAP   = 14;
  localparam int B_BREAK   = 12;
  localparam int B_DMODE   = 3;

  typedef enum logic [2:0] {
    SEL_BYPASS, SEL_ID, SEL_IMPL, SEL_ADDR, SEL_DATA, SEL_CTRL, SEL_CHAIN, SEL_FAST
  } regSel_e;

  typedef struct packed {
    logic    capture;
    logic    shift;
    logic    update;
    regSel_e sel;
  } scanCtl_t;
endpackage

// File: rtl/debugTapCtrl.sv
module debugTapCtrl
  import debugTapPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  input  logic            updateIr,
  input  logic [IR_W-1:0] irCode,
  output scanCtl_t        ctl
);
  logic [IR_W-1:0] irReg;
  regSel_e         sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         irReg <= IR_DEVID;
    else if (updateIr) irReg <= irCode;
  end

  always_comb begin
    case (irReg)
      IR_DEVID: sel = SEL_ID;
      IR_IMPL:  sel = SEL_IMPL;
      IR_ADDR:  sel = SEL_ADDR;
      IR_DATA:  sel = SEL_DATA;
      IR_CTRL:  sel = SEL_CTRL;
      IR_CHAIN: sel = SEL_CHAIN;
      IR_FAST:  sel = SEL_FAST;
      default:  sel = SEL_BYPASS;
    endcase
  end

  assign ctl.capture = captureDr;
  assign ctl.shift   = shiftDr;
  assign ctl.update  = updateDr;
  assign ctl.sel     = sel;
endmodule

// File: rtl/debugTapPath.sv
module debugTapPath
  import debugTapPkg::*;
#(
  parameter logic [DW-1:0] ID_VALUE   = 32'h0A5C_1F03,
  parameter logic [DW-1:0] IMPL_VALUE = 32'h4100_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  scanCtl_t      ctl,
  input  logic          tdi,
  output logic          tdo,
  input  logic          coreReq,
  input  logic          coreWrite,
  input  logic [1:0]    coreSize,
  input  logic [DW-1:0] coreAddr,
  input  logic [DW-1:0] coreWdata,
  output logic          coreAck,
  output logic [DW-1:0] coreRdata,
  input  logic          debugMode,
  output logic          dbgIntReq,
  output logic          periphReset,
  output logic          probeEn,
  output logic          probeTrap
);
  logic [SR_W-1:0]  scanReg, capVal, shiftNxt;
  logic [LEN_W-1:0] topIdx;
  logic [DW-1:0]    addrReg, dataReg, ctrlWord, ctrlIn, dataIn;
  logic [1:0]       sizeReg;
  logic             isStore, pending, capPend, resetSeen, brkReq;
  logic             wrCtrl, wrData, latchReq, completeReq;

  always_comb begin
    ctrlWord            = '0;
    ctrlWord[B_ROCC]    = resetSeen;
    ctrlWord[B_SIZE+:2] = sizeReg;
    ctrlWord[B_PERIPH]  = periphReset;
    ctrlWord[B_DIR]     = isStore;
    ctrlWord[B_PEND]    = pending;
    ctrlWord[B_PENABLE] = probeEn;
    ctrlWord[B_PTRAP]   = probeTrap;
    ctrlWord[B_BREAK]   = brkReq;
    ctrlWord[B_DMODE]   = debugMode;
  end

  always_comb begin
    case (ctl.sel)
      SEL_ID:    capVal = SR_W'(ID_VALUE);
      SEL_IMPL:  capVal = SR_W'(IMPL_VALUE);
      SEL_ADDR:  capVal = SR_W'(addrReg);
      SEL_DATA:  capVal = SR_W'(dataReg);
      SEL_CTRL:  capVal = SR_W'(ctrlWord);
      SEL_CHAIN: capVal = {ctrlWord, dataReg, addrReg};
      SEL_FAST:  capVal = SR_W'({dataReg, pending});
      default:   capVal = '0;
    endcase
  end

  always_comb begin
    case (ctl.sel)
      SEL_BYPASS: topIdx = '0;
      SEL_FAST:   topIdx = LEN_W'(DW);
      SEL_CHAIN:  topIdx = LEN_W'(SR_W - 1);
      default:    topIdx = LEN_W'(DW - 1);
    endcase
    shiftNxt         = scanReg >> 1;
    shiftNxt[topIdx] = tdi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanReg <= '0;
      capPend <= 1'b0;
    end else if (ctl.capture) begin
      scanReg <= capVal;
      capPend <= pending && (ctl.sel inside {SEL_CTRL, SEL_CHAIN, SEL_FAST});
    end else if (ctl.shift) begin
      scanReg <= shiftNxt;
    end
  end

  assign tdo = scanReg[0];

  // commit decode
  always_comb begin
    wrCtrl = ctl.update && (ctl.sel inside {SEL_CTRL, SEL_CHAIN});
    ctrlIn = (ctl.sel == SEL_CHAIN) ? scanReg[3*DW-1:2*DW] : scanReg[DW-1:0];
    wrData = ctl.update && (ctl.sel inside {SEL_DATA, SEL_CHAIN, SEL_FAST});
    case (ctl.sel)
      SEL_CHAIN: dataIn = scanReg[2*DW-1:DW];
      SEL_FAST:  dataIn = scanReg[DW:1];
      default:   dataIn = scanReg[DW-1:0];
    endcase
    completeReq = ctl.update && capPend &&
                  ((wrCtrl && !ctrlIn[B_PEND]) || (ctl.sel == SEL_FAST && !scanReg[0]));
    latchReq    = coreReq && !pending && !coreAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      coreAck <= 1'b0;
      addrReg <= '0;
      dataReg <= '0;
      sizeReg <= '0;
      isStore <= 1'b0;
    end else begin
      coreAck <= completeReq;
      if (completeReq)   pending <= 1'b0;
      else if (latchReq) pending <= 1'b1;
      if (latchReq) begin
        addrReg <= coreAddr;
        sizeReg <= coreSize;
        isStore <= coreWrite;
      end
      if (latchReq && coreWrite) dataReg <= coreWdata;
      else if (wrData)           dataReg <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetSeen   <= 1'b1;
      brkReq      <= 1'b0;
      periphReset <= 1'b0;
      probeEn     <= 1'b0;
      probeTrap   <= 1'b0;
    end else begin
      if (wrCtrl && !ctrlIn[B_ROCC]) resetSeen <= 1'b0;
      if (debugMode)                        brkReq <= 1'b0;
      else if (wrCtrl && ctrlIn[B_BREAK])   brkReq <= 1'b1;
      if (wrCtrl) begin
        periphReset <= ctrlIn[B_PERIPH];
        probeEn     <= ctrlIn[B_PENABLE];
        probeTrap   <= ctrlIn[B_PTRAP];
      end
    end
  end

  assign coreRdata = dataReg;
  assign dbgIntReq = brkReq;
endmodule

// File: rtl/debugTapRegs.sv
module debugTapRegs
  import debugTapPkg::*;
#(
  parameter logic [DW-1:0] ID_VALUE   = 32'h0A5C_1F03,
  parameter logic [DW-1:0] IMPL_VALUE = 32'h4100_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          captureDr,
  input  logic          shiftDr,
  input  logic          updateDr,
  input  logic          updateIr,
  input  logic [IR_W-1:0] irCode,
  input  logic          tdi,
  output logic          tdo,
  input  logic          coreReq,
  input  logic          coreWrite,
  input  logic [1:0]    coreSize,
  input  logic [DW-1:0] coreAddr,
  input  logic [DW-1:0] coreWdata,
  output logic          coreAck,
  output logic [DW-1:0] coreRdata,
  input  logic          debugMode,
  output logic          dbgIntReq,
  output logic          periphReset,
  output logic          probeEn,
  output logic          probeTrap
);
  scanCtl_t ctl;

  debugTapCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .updateIr(updateIr), .irCode(irCode), .ctl(ctl)
  );

  debugTapPath #(.ID_VALUE(ID_VALUE), .IMPL_VALUE(IMPL_VALUE)) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tdi(tdi), .tdo(tdo),
    .coreReq(coreReq), .coreWrite(coreWrite), .coreSize(coreSize),
    .coreAddr(coreAddr), .coreWdata(coreWdata), .coreAck(coreAck),
    .coreRdata(coreRdata), .debugMode(debugMode), .dbgIntReq(dbgIntReq),
    .periphReset(periphReset), .probeEn(probeEn), .probeTrap(probeTrap)
  );
endmodule

// File: rtl/debugTapRegsChk.sv
module debugTapRegsChk (
  input logic clk,
  input logic rstN,
  input logic captureDr,
  input logic shiftDr,
  input logic updateDr,
  input logic tdo,
  input logic coreAck,
  input logic dbgIntReq,
  input logic periphReset
);
  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    coreAck |=> !coreAck);

  assert_ack_after_update_R6: assert property (@(posedge clk) disable iff (!rstN)
    coreAck |-> $past(updateDr));

  assert_break_from_update_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgIntReq) |-> $past(updateDr));

  assert_periph_on_update_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(updateDr) |-> $stable(periphReset));

  assert_tdo_moves_on_scan_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(captureDr) && !$past(shiftDr)) |-> $stable(tdo));
endmodule

bind debugTapRegs debugTapRegsChk chk_i (.*);

// File: tb/debugTapRegs_tb.sv
module debugTapRegs_tb_top;
  localparam logic [31:0] IDV   = 32'h0A5C_1F03;
  localparam logic [31:0] IMPLV = 32'h4100_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic captureDr = 0, shiftDr = 0, updateDr = 0, updateIr = 0, tdi = 0;
  logic [4:0] irCode = 5'h0;
  logic coreReq = 0, coreWrite = 0, debugMode = 0;
  logic [1:0] coreSize = 0;
  logic [31:0] coreAddr = 0, coreWdata = 0;
  logic tdo, coreAck, dbgIntReq, periphReset, probeEn, probeTrap;
  logic [31:0] coreRdata;

  always #5 clk = ~clk;

  debugTapRegs #(.ID_VALUE(IDV), .IMPL_VALUE(IMPLV)) dut_i (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .updateIr(updateIr), .irCode(irCode), .tdi(tdi), .tdo(tdo),
    .coreReq(coreReq), .coreWrite(coreWrite), .coreSize(coreSize),
    .coreAddr(coreAddr), .coreWdata(coreWdata), .coreAck(coreAck),
    .coreRdata(coreRdata), .debugMode(debugMode), .dbgIntReq(dbgIntReq),
    .periphReset(periphReset), .probeEn(probeEn), .probeTrap(probeTrap)
  );

  // behavioural model state
  int nCmp = 0, nBad = 0;
  bit runCmp = 0, done = 0;
  string curReq = "R1";
  logic [4:0]  mIr = 5'h01;
  logic        mRocc = 1, mPeriph = 0, mProbEn = 0, mProbTrap = 0, mBrk = 0;
  logic        mPend = 0, mPrnw = 0, expTdo = 0, expAck = 0;
  logic [1:0]  mSize = 0;
  logic [31:0] mAddr = 0, mData = 0, expRdata = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (runCmp && !done) begin
      chk({31'b0, tdo}, {31'b0, expTdo}, curReq, "tdo");
      chk({31'b0, coreAck}, {31'b0, expAck}, "R6", "coreAck");
      if (expAck) chk(coreRdata, expRdata, "R6", "coreRdata");
      chk({31'b0, dbgIntReq}, {31'b0, mBrk}, "R8", "dbgIntReq");
      chk({31'b0, periphReset}, {31'b0, mPeriph}, "R9", "periphReset");
      chk({31'b0, probeEn}, {31'b0, mProbEn}, "R9", "probeEn");
      chk({31'b0, probeTrap}, {31'b0, mProbTrap}, "R9", "probeTrap");
    end
  end

  function automatic int defLen();
    case (mIr)
      5'h01, 5'h03, 5'h08, 5'h09, 5'h0A: return 32;
      5'h0B: return 96;
      5'h0E: return 33;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] mCtrlWord();
    logic [31:0] w = 0;
    w[31] = mRocc; w[30:29] = mSize; w[20] = mPeriph; w[19] = mPrnw;
    w[18] = mPend; w[15] = mProbEn; w[14] = mProbTrap; w[12] = mBrk; w[3] = debugMode;
    return w;
  endfunction

  function automatic logic [95:0] mCapture();
    case (mIr)
      5'h01: return {64'b0, IDV};
      5'h03: return {64'b0, IMPLV};
      5'h08: return {64'b0, mAddr};
      5'h09: return {64'b0, mData};
      5'h0A: return {64'b0, mCtrlWord()};
      5'h0B: return {mCtrlWord(), mData, mAddr};
      5'h0E: return {63'b0, mData, mPend};
      default: return 96'b0;
    endcase
  endfunction

  // control word the probe writes: keeps config bits unless told otherwise
  function automatic logic [31:0] ctrlIn(input logic rocc, input logic pracc, input logic brk,
                                         input logic per, input logic pen, input logic ptr);
    logic [31:0] w = 0;
    w[31] = rocc; w[18] = pracc; w[12] = brk; w[20] = per; w[15] = pen; w[14] = ptr;
    return w;
  endfunction

  task automatic finishAccess();
    mPend = 0; expAck = 1; expRdata = mData;
  endtask

  task automatic applyCtrl(input logic [31:0] w, input logic capP);
    if (!w[31]) mRocc = 0;
    mPeriph = w[20]; mProbEn = w[15]; mProbTrap = w[14];
    if (w[12] && !debugMode) mBrk = 1;
    if (capP && !w[18]) finishAccess();
  endtask

  task automatic setIr(input logic [4:0] c);
    @(negedge clk); updateIr = 1; irCode = c; mIr = c;
    @(negedge clk); updateIr = 0;
  endtask

  task automatic scan(input int len, input logic [95:0] din);
    logic [95:0] capv;
    logic capP;
    int dl;
    dl = defLen();
    capv = mCapture();
    capP = mPend && (mIr == 5'h0A || mIr == 5'h0B || mIr == 5'h0E);
    @(negedge clk); captureDr = 1; expTdo = capv[0];
    for (int k = 0; k < len; k++) begin
      @(negedge clk); captureDr = 0; shiftDr = 1; tdi = din[k];
      expTdo = (k + 1 < dl) ? capv[k+1] : din[k+1-dl];
    end
    @(negedge clk); captureDr = 0; shiftDr = 0; updateDr = 1;
    case (mIr)
      5'h09: mData = din[31:0];
      5'h0A: applyCtrl(din[31:0], capP);
      5'h0B: begin mData = din[63:32]; applyCtrl(din[95:64], capP); end
      5'h0E: begin mData = din[32:1]; if (capP && !din[0]) finishAccess(); end
      default: ;
    endcase
    @(negedge clk); updateDr = 0;
    if (expAck) begin expAck = 0; coreReq = 0; end
  endtask

  task automatic request(input logic wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    coreReq = 1; coreWrite = wr; coreSize = sz; coreAddr = a; coreWdata = d;
    mPend = 1; mPrnw = wr; mSize = sz; mAddr = a;
    if (wr) mData = d;
    @(negedge clk);
  endtask

  task automatic setDbg(input logic v);
    @(negedge clk); debugMode = v;
    if (v) mBrk = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; runCmp = 1;
    @(negedge clk);
    // R1: reset instruction selects the identifier
    curReq = "R1"; scan(32, 96'h0);
    setIr(5'h03); scan(32, 96'hFFFF_FFFF);
    // R2: bypass codes, longer scans show one-bit delay
    curReq = "R2";
    setIr(5'h00); scan(4, 96'hB);
    setIr(5'h02); scan(3, 96'h5);
    setIr(5'h1C); scan(3, 96'h6);
    setIr(5'h1F); scan(2, 96'h3);
    // R5 and R9: control word readback and config bits
    curReq = "R9"; setIr(5'h0A);
    scan(32, {64'b0, ctrlIn(1, 1, 0, 1, 1, 1)});
    curReq = "R5"; scan(32, {64'b0, ctrlIn(1, 1, 0, 0, 1, 0)});
    // R7: write 1 keeps, write 0 clears, write 1 does not set back
    curReq = "R7";
    scan(32, {64'b0, ctrlIn(1, 1, 0, 0, 1, 0)});
    scan(32, {64'b0, ctrlIn(0, 1, 0, 0, 1, 0)});
    scan(32, {64'b0, ctrlIn(1, 1, 0, 0, 1, 0)});
    // R8: break request set, write 0 no effect, cleared by debug mode
    curReq = "R8";
    scan(32, {64'b0, ctrlIn(1, 1, 1, 0, 1, 0)});
    scan(32, {64'b0, ctrlIn(1, 1, 0, 0, 1, 0)});
    setDbg(1);
    scan(32, {64'b0, ctrlIn(1, 1, 0, 0, 1, 0)});
    setDbg(0);
    // R4 and R12: store latched, address read-only
    curReq = "R4"; request(1, 2'd2, 32'h8000_1230, 32'hCAFE_F00D);
    curReq = "R12"; setIr(5'h08); scan(32, 96'h1111_2222);
    scan(32, 96'h0);
    curReq = "R4"; setIr(5'h09); scan(32, {64'b0, mData});
    // R6: pending bit 1 keeps access, 0 completes
    curReq = "R6"; setIr(5'h0A);
    scan(32, {64'b0, ctrlIn(1, 1, 0, 0, 1, 0)});
    scan(32, {64'b0, ctrlIn(1, 0, 0, 0, 1, 0)});
    scan(32, {64'b0, ctrlIn(1, 0, 0, 0, 1, 0)});
    // load: data scanned in then completed; triple size for R5
    curReq = "R5"; request(0, 2'd3, 32'h0000_4444, 32'h0);
    setIr(5'h0A); scan(32, {64'b0, ctrlIn(1, 1, 0, 0, 1, 0)});
    curReq = "R6"; setIr(5'h09); scan(32, {64'b0, 32'h1357_9BDF});
    setIr(5'h0A); scan(32, {64'b0, ctrlIn(1, 0, 0, 0, 1, 0)});
    // R10: chain access completes a byte load
    curReq = "R10"; request(0, 2'd0, 32'h0BAD_0001, 32'h0);
    setIr(5'h0B);
    scan(96, {ctrlIn(1, 1, 0, 1, 1, 0), 32'hAAAA_5555, 32'hFFFF_0000});
    scan(96, {ctrlIn(1, 0, 0, 0, 1, 0), 32'h2468_ACE0, 32'h0});
    scan(96, {ctrlIn(1, 1, 0, 0, 1, 0), mData, 32'h0});
    // R11: fast-data flag 1 keeps pending, 0 completes, idle capture 0
    curReq = "R11"; request(1, 2'd1, 32'h0000_7770, 32'h0F0F_0F0F);
    setIr(5'h0E);
    scan(33, {63'b0, 32'h1234_5678, 1'b1});
    scan(33, {63'b0, 32'h9ABC_DEF0, 1'b0});
    scan(33, {63'b0, 32'h5555_AAAA, 1'b0});
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule